// File: doc/BRIEF.md
# I2C Slave Address and Bus-Status Monitor

This block listens passively to the clock and data lines of an I2C bus and keeps a small set of read-only status flags for a slave controller. It resynchronises both lines to the system clock and finds START, repeated START and STOP conditions. From these it tracks whether the bus is in use. After every START it shifts in the address phase and compares it with a programmed own address. Both the 7-bit form and the two-byte 10-bit form are supported.

The result is three flags: addressed as slave, addressed by a general call, and the direction the master asked for. These flags, the bus-busy flag and four FIFO level inputs from the surrounding controller are registered into one 32-bit status word. Software reads that word through a plain read port. The block never drives either bus line and takes no part in acknowledging or moving data.

Top module: `i2c_addr_monitor`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. SDA changes while SCL is low are not bus conditions and leave the bus-busy flag unchanged.
- R2: The bus-busy flag becomes 1 after a START and 0 after a STOP, and keeps its value otherwise.
- R3: In 7-bit mode (`ten_bit_mode`=0), address bits are taken on rising SCL, MSB first. If the 7 address bits of the first byte equal `own_addr[6:0]` and the byte is not 0x00, the addressed flag is set and the direction flag takes the byte's last bit (1 = master reads, 0 = master writes). The direction flag is 1 only while the addressed flag is 1.
- R4: A STOP or any START, including a repeated START, clears the addressed, general-call and direction flags.
- R5: A first byte of 0x00 is a general call. It sets the general-call flag when `gc_enable`=1 and has no effect when `gc_enable`=0. It never sets the addressed flag.
- R6: In 10-bit mode, a first byte of 11110, then `own_addr[9:8]`, then direction 0, followed after its acknowledge clock by a second byte equal to `own_addr[7:0]`, sets the addressed flag with direction 0. The header alone sets nothing.
- R7: In 10-bit mode, a header with direction 1 sets the addressed flag and direction 1 only if a full 10-bit match has occurred since the last STOP.
- R8: In 10-bit mode, 7-bit addresses are ignored, even one equal to `own_addr[6:0]`. A general call is still recognised under R5.
- R9: `status_word` bits, counted from the LSB, are: 7 transmit FIFO empty, 6 receive FIFO empty, 5 receive FIFO full, 4 transmit FIFO full, 3 direction, 2 bus busy, 1 addressed, 0 general call. Bits 31:8 are 0. Each bit shows its source one clock later.
- R10: While `rst_n` is 0 at a clock edge, `status_word` becomes 0x000000C0, whatever the FIFO inputs are.
- R11: A first byte or second byte that does not match leaves the addressed flag at 0 until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| own_addr | input | 10 | Programmed slave address; bits 6:0 are used in 7-bit mode |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| gc_enable | input | 1 | 1 enables general-call recognition |
| tx_fifo_empty | input | 1 | Transmit FIFO empty level |
| rx_fifo_empty | input | 1 | Receive FIFO empty level |
| rx_fifo_full | input | 1 | Receive FIFO full level (all 16 entries used) |
| tx_fifo_full | input | 1 | Transmit FIFO full level |
| status_word | output | 32 | Registered status word |

## Verification
The assertions check the following on every cycle: bus-busy follows START and STOP and holds between them, every condition clears the three address flags, the general-call flag rises only when it is enabled, the addressed and general-call flags are never both set, and the direction flag is never set without the addressed flag. The bench's scenarios are the only way to show that an address is decoded correctly. This covers MSB-first shifting, the 7-bit and 10-bit comparisons, the header-only case, the 10-bit read that needs an earlier match, and 7-bit addresses being ignored in 10-bit mode. The bench also checks the packed bit layout and the reset value of the status word.

// File: rtl/i2c_mon_pkg.sv
// Shared types and constants for the I2C address and bus-status monitor.
// Assumes the bus carries 8-bit bytes with a ninth acknowledge clock.
package i2c_mon_pkg;
    localparam int BYTE_BITS   = 8;
    localparam int ADDR_W      = 10;
    localparam int BITCNT_W    = $clog2(BYTE_BITS + 1);
    localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

    typedef enum logic [1:0] {
        AM_IDLE,
        AM_FIRST,
        AM_SECOND,
        AM_SKIP
    } am_state_t;

    typedef struct packed {
        logic tx_empty;
        logic rx_empty;
        logic rx_full;
        logic tx_full;
        logic dir_read;
        logic busy;
        logic addressed;
        logic gen_call;
    } stat_flags_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Multi-stage synchroniser with edge detection for a set of asynchronous lines.
// Assumes idle-high lines (open-drain bus), so every stage resets to 1.
// STAGES must be at least 2.
module i2c_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the raw line through the synchroniser and keep the last level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
                prev  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                prev  <= chain[STAGES-1];
            end
        end

        assign level[g] = chain[STAGES-1];
        assign rise[g]  = chain[STAGES-1] & ~prev;
        assign fall[g]  = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/i2c_cond_detect.sv
// Finds START and STOP conditions on synchronised lines and keeps the bus-busy flag.
// Assumes inputs are already synchronised, so both lines have equal latency.
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_p,
    output logic stop_p,
    output logic bus_busy
);
    assign start_p = sda_fall & scl_lvl;
    assign stop_p  = sda_rise & scl_lvl;

    // Bus-busy flag: set by START, cleared by STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)       bus_busy <= 1'b0;
        else if (start_p) bus_busy <= 1'b1;
        else if (stop_p)  bus_busy <= 1'b0;
    end

    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> bus_busy);
    p_busy_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !bus_busy);
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_p && !stop_p) |=> $stable(bus_busy));
endmodule

// File: rtl/i2c_addr_match.sv
// Shifts in the address phase after each START and decides slave match,
// general call and direction, for 7-bit and 10-bit addressing.
// Assumes one-cycle pulses for START, STOP and SCL rising, and a data level
// that is stable at the SCL rising pulse.
module i2c_addr_match
    import i2c_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              scl_rise,
    input  logic              sda_lvl,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_mode,
    input  logic              gc_enable,
    output logic              addressed,
    output logic              gen_call,
    output logic              dir_read
);
    localparam logic [BITCNT_W-1:0] LAST_DATA = BITCNT_W'(BYTE_BITS - 1);
    localparam logic [BITCNT_W-1:0] ACK_SLOT  = BITCNT_W'(BYTE_BITS);

    am_state_t            state;
    logic [BITCNT_W-1:0]  bit_cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic                 to_second;
    logic                 ten_armed;

    logic [BYTE_BITS-1:0] byte_next;
    logic                 is_gc;
    logic                 seven_hit;
    logic                 hdr_hit;
    logic                 low_hit;
    logic                 in_byte;

    // Decode of the byte completed by the current bit.
    always_comb begin
        byte_next = {shreg[BYTE_BITS-2:0], sda_lvl};
        is_gc     = (byte_next == '0);
        seven_hit = (byte_next[7:1] == own_addr[6:0]) && !is_gc;
        hdr_hit   = (byte_next[7:3] == TEN_BIT_PREFIX) && (byte_next[2:1] == own_addr[9:8]);
        low_hit   = (byte_next == own_addr[7:0]);
        in_byte   = (state == AM_FIRST) || (state == AM_SECOND);
    end

    // Address phase sequencer and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= AM_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            to_second <= 1'b0;
            ten_armed <= 1'b0;
            addressed <= 1'b0;
            gen_call  <= 1'b0;
            dir_read  <= 1'b0;
        end else if (stop_p) begin
            state     <= AM_IDLE;
            bit_cnt   <= '0;
            to_second <= 1'b0;
            ten_armed <= 1'b0;
            addressed <= 1'b0;
            gen_call  <= 1'b0;
            dir_read  <= 1'b0;
        end else if (start_p) begin
            state     <= AM_FIRST;
            bit_cnt   <= '0;
            to_second <= 1'b0;
            addressed <= 1'b0;
            gen_call  <= 1'b0;
            dir_read  <= 1'b0;
        end else if (scl_rise && in_byte) begin
            if (bit_cnt == ACK_SLOT) begin
                bit_cnt   <= '0;
                state     <= to_second ? AM_SECOND : AM_SKIP;
                to_second <= 1'b0;
            end else begin
                shreg   <= byte_next;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_DATA) begin
                    if (state == AM_FIRST) begin
                        if (is_gc) begin
                            gen_call <= gc_enable;
                        end else if (!ten_bit_mode) begin
                            if (seven_hit) begin
                                addressed <= 1'b1;
                                dir_read  <= byte_next[0];
                            end
                        end else if (hdr_hit) begin
                            if (!byte_next[0]) begin
                                to_second <= 1'b1;
                            end else if (ten_armed) begin
                                addressed <= 1'b1;
                                dir_read  <= 1'b1;
                            end
                        end
                    end else if (low_hit) begin
                        addressed <= 1'b1;
                        dir_read  <= 1'b0;
                        ten_armed <= 1'b1;
                    end
                end
            end
        end
    end

    p_clear_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (!addressed && !gen_call && !dir_read));
    p_clear_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> (!addressed && !gen_call && !dir_read));
    p_gc_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_call) |-> $past(gc_enable));
    p_gc_not_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(addressed && gen_call));
    p_dir_needs_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dir_read |-> addressed);
endmodule

// File: rtl/i2c_status_pack.sv
// Registers the monitor flags and FIFO levels into the 32-bit status word.
// Assumes FIFO level inputs are synchronous to clk.
module i2c_status_pack
    import i2c_mon_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_fifo_empty,
    input  logic              rx_fifo_empty,
    input  logic              rx_fifo_full,
    input  logic              tx_fifo_full,
    input  logic              dir_read,
    input  logic              bus_busy,
    input  logic              addressed,
    input  logic              gen_call,
    output logic [WORD_W-1:0] status_word
);
    localparam int FLAG_W = $bits(stat_flags_t);
    localparam stat_flags_t RESET_FLAGS = '{tx_empty: 1'b1, rx_empty: 1'b1, default: 1'b0};

    stat_flags_t flags_q;

    // Capture all status sources once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= RESET_FLAGS;
        end else begin
            flags_q.tx_empty  <= tx_fifo_empty;
            flags_q.rx_empty  <= rx_fifo_empty;
            flags_q.rx_full   <= rx_fifo_full;
            flags_q.tx_full   <= tx_fifo_full;
            flags_q.dir_read  <= dir_read;
            flags_q.busy      <= bus_busy;
            flags_q.addressed <= addressed;
            flags_q.gen_call  <= gen_call;
        end
    end

    assign status_word = {{(WORD_W-FLAG_W){1'b0}}, flags_q};

    p_busy_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[2] == $past(bus_busy));
endmodule

// File: rtl/i2c_addr_monitor.sv
// Top of the I2C slave address and bus-status monitor: synchroniser,
// condition detector, address matcher and status packer.
// Assumes a system clock several times faster than SCL; never drives the bus.
module i2c_addr_monitor
    import i2c_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_mode,
    input  logic              gc_enable,
    input  logic              tx_fifo_empty,
    input  logic              rx_fifo_empty,
    input  logic              rx_fifo_full,
    input  logic              tx_fifo_full,
    output logic [31:0]       status_word
);
    localparam int SCL_IDX = 0;
    localparam int SDA_IDX = 1;

    logic [1:0] lvl, rise, fall;
    logic       start_p, stop_p, bus_busy;
    logic       addressed, gen_call, dir_read;
    logic       unused_scl_fall;

    assign unused_scl_fall = fall[SCL_IDX];

    i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sda_in, scl_in}),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    i2c_cond_detect u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (lvl[SCL_IDX]),
        .sda_rise (rise[SDA_IDX]),
        .sda_fall (fall[SDA_IDX]),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .bus_busy (bus_busy)
    );

    i2c_addr_match u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_p      (start_p),
        .stop_p       (stop_p),
        .scl_rise     (rise[SCL_IDX]),
        .sda_lvl      (lvl[SDA_IDX]),
        .own_addr     (own_addr),
        .ten_bit_mode (ten_bit_mode),
        .gc_enable    (gc_enable),
        .addressed    (addressed),
        .gen_call     (gen_call),
        .dir_read     (dir_read)
    );

    i2c_status_pack #(.WORD_W(32)) u_pack (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_fifo_empty (tx_fifo_empty),
        .rx_fifo_empty (rx_fifo_empty),
        .rx_fifo_full  (rx_fifo_full),
        .tx_fifo_full  (tx_fifo_full),
        .dir_read      (dir_read),
        .bus_busy      (bus_busy),
        .addressed     (addressed),
        .gen_call      (gen_call),
        .status_word   (status_word)
    );

    p_start_stop_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_p && stop_p));
endmodule

// File: tb/i2c_addr_monitor_test.sv
`timescale 1ns/1ps
module i2c_addr_monitor_test;
    localparam int PH = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda = 1'b1;
    logic [9:0]  own_addr = '0;
    logic        ten_bit = 1'b0;
    logic        gc_en = 1'b0;
    logic        tx_e = 1'b0, rx_e = 1'b0, rx_f = 1'b1, tx_f = 1'b1;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    i2c_addr_monitor uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl),
        .sda_in        (sda),
        .own_addr      (own_addr),
        .ten_bit_mode  (ten_bit),
        .gc_enable     (gc_en),
        .tx_fifo_empty (tx_e),
        .rx_fifo_empty (rx_e),
        .rx_fifo_full  (rx_f),
        .tx_fifo_full  (tx_f),
        .status_word   (status)
    );

    task automatic wait_ph();
        repeat (PH) @(posedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        @(negedge clk);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Low nibble: bit3 direction, bit2 busy, bit1 addressed, bit0 general call.
    task automatic check_flags(input string req, input logic [3:0] exp);
        @(negedge clk);
        check(req, {28'd0, status[3:0]}, {28'd0, exp});
    endtask

    task automatic bus_start();
        sda = 1'b0; wait_ph();
        scl = 1'b0; wait_ph();
    endtask

    task automatic bus_rstart();
        sda = 1'b1; wait_ph();
        scl = 1'b1; wait_ph();
        sda = 1'b0; wait_ph();
        scl = 1'b0; wait_ph();
    endtask

    task automatic bus_stop();
        sda = 1'b0; wait_ph();
        scl = 1'b1; wait_ph();
        sda = 1'b1; wait_ph();
    endtask

    task automatic bus_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda = b[i]; wait_ph();
            scl = 1'b1; wait_ph();
            scl = 1'b0; wait_ph();
        end
        sda = 1'b1; wait_ph();
        scl = 1'b1; wait_ph();
        scl = 1'b0; wait_ph();
    endtask

    task automatic t_reset();
        repeat (5) @(posedge clk);
        check("R10 reset value", status, 32'h0000_00C0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        check("R9 fifo pattern 0011", status, 32'h0000_0030);
        tx_e = 1'b1; rx_e = 1'b0; rx_f = 1'b1; tx_f = 1'b0;
        repeat (3) @(posedge clk);
        check("R9 fifo pattern 1010", status, 32'h0000_00A0);
        tx_e = 1'b1; rx_e = 1'b1; rx_f = 1'b0; tx_f = 1'b0;
        repeat (3) @(posedge clk);
        check("R9 fifo pattern 1100", status, 32'h0000_00C0);
    endtask

    task automatic t_busy();
        bus_start();
        check_flags("R2 busy after START", 4'b0100);
        bus_stop();
        check_flags("R2 idle after STOP", 4'b0000);
        scl = 1'b0; wait_ph();
        sda = 1'b0; wait_ph();
        check_flags("R1 SDA fall with SCL low", 4'b0000);
        sda = 1'b1; wait_ph();
        scl = 1'b1; wait_ph();
        check_flags("R1 SDA rise with SCL low", 4'b0000);
    endtask

    task automatic t_seven_bit();
        own_addr = 10'h03A; ten_bit = 1'b0; gc_en = 1'b1;
        bus_start();
        bus_byte(8'h74);
        check_flags("R3 7-bit write match", 4'b0110);
        bus_rstart();
        check_flags("R4 repeated START clears", 4'b0100);
        bus_byte(8'h75);
        check_flags("R3 7-bit read match", 4'b1110);
        bus_stop();
        check_flags("R4 STOP clears", 4'b0000);
        bus_start();
        bus_byte(8'h76);
        check_flags("R11 7-bit mismatch", 4'b0100);
        bus_stop();
    endtask

    task automatic t_gen_call();
        own_addr = 10'h03A; ten_bit = 1'b0; gc_en = 1'b1;
        bus_start();
        bus_byte(8'h00);
        check_flags("R5 general call enabled", 4'b0101);
        gc_en = 1'b0;
        bus_rstart();
        check_flags("R4 repeated START clears gc", 4'b0100);
        bus_byte(8'h00);
        check_flags("R5 general call disabled", 4'b0100);
        bus_stop();
    endtask

    task automatic t_ten_bit();
        own_addr = 10'h2C5; ten_bit = 1'b1; gc_en = 1'b1;
        bus_start();
        bus_byte(8'hF4);
        check_flags("R6 header alone", 4'b0100);
        bus_byte(8'hC5);
        check_flags("R6 10-bit write match", 4'b0110);
        bus_rstart();
        bus_byte(8'hF5);
        check_flags("R7 10-bit read after match", 4'b1110);
        bus_stop();
        check_flags("R4 STOP clears 10-bit", 4'b0000);
        bus_start();
        bus_byte(8'hF5);
        check_flags("R7 10-bit read not armed", 4'b0100);
        bus_stop();
        bus_start();
        bus_byte(8'hF4);
        bus_byte(8'hC4);
        check_flags("R11 10-bit low byte mismatch", 4'b0100);
        bus_stop();
    endtask

    task automatic t_ten_bit_ignore();
        own_addr = 10'h2C5; ten_bit = 1'b1; gc_en = 1'b1;
        bus_start();
        bus_byte(8'h8A);
        check_flags("R8 7-bit address ignored", 4'b0100);
        bus_rstart();
        bus_byte(8'h00);
        check_flags("R8 general call in 10-bit mode", 4'b0101);
        bus_stop();
        check_flags("R4 STOP clears gc", 4'b0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_busy();
        t_seven_bit();
        t_gen_call();
        t_ten_bit();
        t_ten_bit_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule